// File: doc/BRIEF.md
# Integer multiply unit with selectable product word

This block multiplies two 32-bit operands for an integer core and returns one 32-bit word of the 64-bit product. A two-bit mode input selects the word and the signedness: the low word, or the high word with both operands signed, the first signed and the second unsigned, or both unsigned. Every mode goes through the same datapath. The first operand is extended by sign or by zero. The second operand is consumed a few bits per cycle. When the second operand is negative and treated as signed, its weight is applied as a correction that is preloaded into the accumulator.

Requests and results each use their own valid/ready pair. A request is taken when `in_valid_i` and `in_ready_o` are both high, and the operands and the mode are registered at that edge. After `32/STEP_BITS` step cycles the selected word appears on `result_o` with `out_valid_o` high. It stays there, unchanged, until `out_ready_i` is seen. The input side opens again in the cycle that consumes the result, so a new request can be taken in that same cycle.

Top module: `mulu_top`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Mode 2'b00 returns product bits 31:0, which do not depend on signedness (0xaaaaaaab*0x0002fe7d=0x0000ff7f, 0xffffffff*0xffffffff=0x00000001).
- R3: Mode 2'b01 returns bits 63:32 with both operands in two's complement (0xffffffff*0xffffffff=0x00000000, 0xff000000*0xff000000=0x00010000).
- R4: Mode 2'b10 returns bits 63:32 with `op_a_i` signed and `op_b_i` unsigned, so operand order matters (0x80000000*0xffff8000=0x80004000, 0x0002fe7d*0xaaaaaaab=0x0001fefe, 0xaaaaaaab*0x0002fe7d=0xffff0081).
- R5: Mode 2'b11 returns bits 63:32 with both operands unsigned (0x80000000*0xffff8000=0x7fffc000, 0xffffffff*0xffffffff=0xfffffffe).
- R6: If either operand is zero, the result is zero in every mode.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `result_o` holds its value.
- R8: Operands and mode are captured at the accepting edge, so later changes on the inputs have no effect. `in_ready_o` is low while a product is being formed, and also while a result waits and `out_ready_i` is low.
- R9: When `out_ready_i` is high in the cycle a result is shown, `in_ready_o` is high too, and a new request can be accepted in that same cycle.
- R10: `out_valid_o` rises exactly `32/STEP_BITS` clock edges after the accepting edge (8 with the default STEP_BITS=4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Unit can take a request |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| mode_i | input | 2 | 00 low word, 01 high signed×signed, 10 high signed×unsigned, 11 high unsigned×unsigned |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Selected product word |

## Verification
Two functions can fall in the same cycle: handing over a finished result and accepting the next request. The bench holds a request valid while the previous product is still being formed, and it keeps `out_ready_i` high, so the hand-over and the acceptance meet on one edge. The scoreboard then checks that the new result is correct, that the old one was delivered once, and that the new result arrives exactly the step count after its own acceptance. Other phases stall `out_ready_i` at random to check that the result is held, and they scramble the operand inputs after acceptance.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  typedef enum logic [1:0] {
    MODE_LO  = 2'b00,
    MODE_HSS = 2'b01,
    MODE_HSU = 2'b10,
    MODE_HUU = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_DONE = 2'b10
  } state_e;
endpackage

// File: rtl/mulu_operand_prep.sv
module mulu_operand_prep
  import mulu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   op_a_i,
  input  logic [W-1:0]   op_b_i,
  input  mode_e          mode_i,
  output logic [2*W-1:0] mcand_o,
  output logic [W-1:0]   mplier_o,
  output logic [2*W-1:0] acc_init_o
);
  logic a_sgn, b_sgn;
  logic [W-1:0] a_neg;

  assign a_sgn = (mode_i != MODE_HUU);
  assign b_sgn = (mode_i == MODE_HSS);
  assign a_neg = ~op_a_i + W'(1);

  assign mcand_o  = {{W{a_sgn & op_a_i[W-1]}}, op_a_i};
  assign mplier_o = op_b_i;
  // A negative signed multiplier weighs its top bit as -2^W: preload -a*2^W
  assign acc_init_o = (b_sgn && op_b_i[W-1]) ? {a_neg, {W{1'b0}}} : '0;
endmodule

// File: rtl/mulu_step_core.sv
module mulu_step_core #(
  parameter int unsigned W         = 32,
  parameter int unsigned STEP_BITS = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] mcand_i,
  input  logic [W-1:0]   mplier_i,
  input  logic [2*W-1:0] acc_init_i,
  output logic [2*W-1:0] acc_next_o,
  output logic           last_o
);
  localparam int unsigned NSTEP = W / STEP_BITS;
  localparam int unsigned CW    = $clog2(NSTEP + 1);

  logic [2*W-1:0] acc_q, mcand_q;
  logic [W-1:0]   mplier_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] pp [STEP_BITS];
  logic [2*W-1:0] pp_sum;

  for (genvar j = 0; j < STEP_BITS; j++) begin : g_pp
    assign pp[j] = mplier_q[j] ? (mcand_q << j) : '0;
  end

  always_comb begin
    pp_sum = '0;
    for (int j = 0; j < STEP_BITS; j++) pp_sum = pp_sum + pp[j];
  end

  assign acc_next_o = acc_q + pp_sum;
  assign last_o     = (cnt_q == CW'(NSTEP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      acc_q    <= acc_init_i;
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      cnt_q    <= '0;
    end else if (step_i) begin
      acc_q    <= acc_next_o;
      mcand_q  <= mcand_q << STEP_BITS;
      mplier_q <= mplier_q >> STEP_BITS;
      cnt_q    <= cnt_q + CW'(1);
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q < CW'(NSTEP)));
  p_load_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/mulu_word_sel.sv
module mulu_word_sel
  import mulu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] prod_i,
  input  mode_e          mode_i,
  output logic [W-1:0]   word_o
);
  always_comb begin
    unique case (mode_i)
      MODE_LO: word_o = prod_i[W-1:0];
      default: word_o = prod_i[2*W-1:W];
    endcase
  end
endmodule

// File: rtl/mulu_top.sv
module mulu_top
  import mulu_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned STEP_BITS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [1:0]   mode_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] result_o
);
  state_e state_q, state_d;
  mode_e  mode_q;
  logic   zero_q;
  logic [W-1:0] res_q;

  logic accept, load, step, last;
  logic [2*W-1:0] mcand, acc_init, acc_next;
  logic [W-1:0]   mplier, word;

  assign in_ready_o  = (state_q == ST_IDLE) || (state_q == ST_DONE && out_ready_i);
  assign out_valid_o = (state_q == ST_DONE);
  assign result_o    = res_q;
  assign accept      = in_valid_i && in_ready_o;
  assign load        = accept;
  assign step        = (state_q == ST_BUSY);

  mulu_operand_prep #(.W(W)) u_prep (
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .mode_i    (mode_e'(mode_i)),
    .mcand_o   (mcand),
    .mplier_o  (mplier),
    .acc_init_o(acc_init)
  );

  mulu_step_core #(.W(W), .STEP_BITS(STEP_BITS)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .acc_init_i(acc_init),
    .acc_next_o(acc_next),
    .last_o    (last)
  );

  mulu_word_sel #(.W(W)) u_sel (
    .prod_i(acc_next),
    .mode_i(mode_q),
    .word_o(word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_BUSY;
      ST_BUSY: if (last) state_d = ST_DONE;
      ST_DONE: if (out_ready_i) state_d = accept ? ST_BUSY : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_LO;
      zero_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q <= mode_e'(mode_i);
        zero_q <= (op_a_i == '0) || (op_b_i == '0);
      end
      if (step && last) res_q <= word;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));
  p_busy_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> !in_ready_o);
  p_wait_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && zero_q) |-> (result_o == '0));
  p_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |-> in_ready_o);
  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !out_valid_o);
endmodule

// File: tb/mulu_top_tb_top.sv
module mulu_top_tb_top;
  localparam int W = 32;
  localparam int STEP_BITS = 4;
  localparam int LAT = W / STEP_BITS;

  typedef struct {
    logic [31:0] exp;
    int          acc_cyc;
    string       req;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [1:0] mode_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b1;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int overlap_seen = 0;
  int stall_pct = 0;
  bit finished = 0;
  item_t sb_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  mulu_top #(.W(W), .STEP_BITS(STEP_BITS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .mode_i(mode_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .result_o(result_o)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [1:0] m);
    longint sa, sb;
    logic [63:0] p;
    sa = (m == 2'b11) ? longint'({32'b0, a}) : longint'($signed(a));
    sb = (m == 2'b01) ? longint'($signed(b)) : longint'({32'b0, b});
    p = 64'(sa * sb);
    return (m == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  task automatic send(logic [31:0] a, logic [31:0] b, logic [1:0] m, string req);
    item_t it;
    @(posedge clk_i); #1;
    op_a_i = a; op_b_i = b; mode_i = m; in_valid_i = 1'b1;
    do @(negedge clk_i); while (!in_ready_o);
    it.exp = model(a, b, m);
    it.acc_cyc = cyc + 1;
    it.req = req;
    sb_q.push_back(it);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    op_a_i = ~a; op_b_i = a ^ b; mode_i = ~m; // R8: scrambled after capture
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk_i);
  endtask

  // out_ready driver: stalls at random with the current percentage
  initial forever begin
    @(posedge clk_i); #1;
    out_ready_i = ($urandom_range(99) >= stall_pct);
  end

  // monitor / scoreboard
  initial begin
    bit seen = 0;
    logic [31:0] held = '0;
    bit holding = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        seen = 0; holding = 0;
      end else begin
        if (holding) begin
          check(out_valid_o == 1'b1, "R7", "valid dropped while stalled", 32'(out_valid_o), 32'd1);
          check(result_o == held, "R7", "result changed while stalled", result_o, held);
        end
        if (sb_q.size() != 0 && !out_valid_o)
          check(in_ready_o == 1'b0, "R8", "ready while forming", 32'(in_ready_o), 32'd0);
        if (out_valid_o && !out_ready_i)
          check(in_ready_o == 1'b0, "R8", "ready while result waits", 32'(in_ready_o), 32'd0);
        if (out_valid_o && out_ready_i)
          check(in_ready_o == 1'b1, "R9", "ready not open on consume", 32'(in_ready_o), 32'd1);
        if (out_valid_o && out_ready_i && in_valid_i && in_ready_o) overlap_seen++;
        if (out_valid_o && !seen) begin
          seen = 1;
          if (sb_q.size() == 0)
            check(1'b0, "R8", "result with nothing pending", result_o, 32'd0);
          else
            check(cyc - sb_q[0].acc_cyc == LAT, "R10", "latency",
                  32'(cyc - sb_q[0].acc_cyc), 32'(LAT));
        end
        if (out_valid_o && out_ready_i && sb_q.size() != 0) begin
          item_t it;
          it = sb_q.pop_front();
          check(result_o == it.exp, it.req, "product word", result_o, it.exp);
          seen = 0; holding = 0;
        end else if (out_valid_o) begin
          holding = 1; held = result_o;
        end else begin
          holding = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1", "out_valid after reset", 32'(out_valid_o), 32'd0);
    check(in_ready_o == 1'b1, "R1", "in_ready after reset", 32'(in_ready_o), 32'd1);

    // directed, consumer always ready
    send(32'haaaaaaab, 32'h0002fe7d, 2'b00, "R2");
    send(32'hffffffff, 32'hffffffff, 2'b00, "R2");
    send(32'h00007e00, 32'hb6db6db7, 2'b00, "R2");
    send(32'hffffffff, 32'hffffffff, 2'b01, "R3");
    send(32'hff000000, 32'hff000000, 2'b01, "R3");
    send(32'haaaaaaab, 32'h0002fe7d, 2'b01, "R3");
    send(32'h80000000, 32'hffff8000, 2'b10, "R4");
    send(32'h0002fe7d, 32'haaaaaaab, 2'b10, "R4");
    send(32'haaaaaaab, 32'h0002fe7d, 2'b10, "R4");
    send(32'hffffffff, 32'hffffffff, 2'b10, "R4");
    send(32'h80000000, 32'hffff8000, 2'b11, "R5");
    send(32'hffffffff, 32'hffffffff, 2'b11, "R5");
    send(32'hff000000, 32'hff000000, 2'b11, "R5");
    for (int m = 0; m < 4; m++) begin
      send(32'h0, 32'hffff8000, 2'(m), "R6");
      send(32'h80000000, 32'h0, 2'(m), "R6");
    end
    drain();

    // stalls on the result side
    stall_pct = 60;
    for (int i = 0; i < 40; i++)
      send($urandom, $urandom, 2'($urandom_range(3)), "R7");
    drain();

    // back-to-back: new request meets the consume cycle
    stall_pct = 0;
    for (int i = 0; i < 40; i++)
      send($urandom, $urandom, 2'($urandom_range(3)), "R9");
    drain();
    check(overlap_seen > 0, "R9", "no same-cycle consume and accept", 32'(overlap_seen), 32'd1);

    // mixed random with moderate stall
    stall_pct = 30;
    for (int i = 0; i < 60; i++)
      send($urandom, $urandom, 2'($urandom_range(3)), "R8");
    drain();

    repeat (4) @(negedge clk_i);
    finished = 1;
    summary();
  end
endmodule